// File: doc/BRIEF.md
# Neural-Network Integer Extension Unit

This block executes three custom integer operations for quantized inference on a 32-bit core. All three share one major opcode and are told apart by the funct3 field of an R-type instruction word.

- **Saturate** shifts a source arithmetically right by a register amount. It then clamps the value to a signed width that the funct7 field selects.
- **Packed dot product** multiplies four signed byte lanes of two sources. It sums the four products and adds the current destination value.
- **Multiply-accumulate** adds the low word of a signed product to the current destination value.

The surrounding core supplies the instruction word and three operand values: rs1, rs2, and the present rd value read as a third source. The block returns a write enable, the destination index and the result one clock after issue. It raises an illegal-instruction flag for malformed encodings within its opcode.

Top module: `nnx_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `wb_en_o` and `illegal_o` are 0.
- R2: An instruction captured with `issue_i`=1 at a rising edge drives the outputs from that edge until the next. After an edge with `issue_i`=0, `wb_en_o` and `illegal_o` are 0.
- R3: If instruction bits [6:0] differ from 7'b0101011, the block asserts neither `wb_en_o` nor `illegal_o`.
- R4: For funct3 (bits [14:12]) = 3'b000, the saturation position p is taken from bits [31:25]. The result is rs1 shifted arithmetically right by rs2, then clamped to [-2^(p-1), 2^(p-1)-1].
- R5: The saturate operation writes nothing, and raises no illegal flag, when p=0, p>32, or rs2>=32 (all 32 bits compared).
- R6: With p=32 the clamp limits equal the full 32-bit signed range, so the result is exactly the shifted value.
- R7: For funct3=3'b001 with funct7=0, the result is the sum of four lane products plus rd, truncated to 32 bits. Each product multiplies signed bytes [7:0], [15:8], [23:16] and [31:24] of rs1 and rs2 in matching lanes.
- R8: For funct3=3'b010 with funct7=0, the result is the low 32 bits of signed rs1 times signed rs2, plus rd.
- R9: A destination index (bits [11:7]) of 0 suppresses the write for every operation.
- R10: Within the opcode, funct3 of 3 to 7, or a non-zero funct7 with funct3 of 1 or 2, sets `illegal_o`=1 with `wb_en_o`=0. `wb_en_o` and `illegal_o` are never both 1.
- R11: Whenever `wb_en_o`=1, `wb_idx_o` equals bits [11:7] of the captured instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Instruction word and operands are valid this cycle |
| instr_i | input | 32 | Instruction word |
| src1_i | input | 32 | Value of rs1 |
| src2_i | input | 32 | Value of rs2 |
| src3_i | input | 32 | Current value of rd |
| wb_en_o | output | 1 | Register write request |
| wb_idx_o | output | 5 | Destination register index |
| wb_data_o | output | 32 | Result to write |
| illegal_o | output | 1 | Malformed encoding inside the block's opcode |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, 8-bit lanes and a 7-bit saturation-position field.

With these values the position field can exceed the datapath width, so the rejected positions 33 and above sit next to the accepted boundary p=32. At p=32 the limit arithmetic needs its extra guard bits.

Four lanes with all bytes at -128 reach the largest lane sum. An accumulator near the positive limit forces wrap-around in both the dot product and the multiply-accumulate.

// File: rtl/nnx_pkg.sv
package nnx_pkg;
   localparam logic [6:0] NNX_OPCODE = 7'b0101011;
   localparam logic [2:0] F3_CLAMP   = 3'd0;
   localparam logic [2:0] F3_DOT     = 3'd1;
   localparam logic [2:0] F3_MACC    = 3'd2;

   typedef enum logic [1:0] {
      OP_NONE,
      OP_CLAMP,
      OP_DOT,
      OP_MACC
   } nnx_op_e;

   typedef struct packed {
      nnx_op_e     op;
      logic        bad;
      logic [4:0]  rd;
      logic [6:0]  pos;
   } nnx_dec_t;
endpackage

// File: rtl/nnx_decode.sv
module nnx_decode
   import nnx_pkg::*;
(
   input  logic [31:0] instr_i,
   output nnx_dec_t    dec_o
);
   logic [6:0] f7;
   logic [2:0] f3;

   assign f7 = instr_i[31:25];
   assign f3 = instr_i[14:12];

   always_comb begin
      dec_o     = '0;
      dec_o.op  = OP_NONE;
      dec_o.rd  = instr_i[11:7];
      dec_o.pos = f7;
      if (instr_i[6:0] == NNX_OPCODE) begin
         unique case (f3)
            F3_CLAMP: dec_o.op = OP_CLAMP;
            F3_DOT: begin
               if (f7 == 7'd0) dec_o.op  = OP_DOT;
               else            dec_o.bad = 1'b1;
            end
            F3_MACC: begin
               if (f7 == 7'd0) dec_o.op  = OP_MACC;
               else            dec_o.bad = 1'b1;
            end
            default: dec_o.bad = 1'b1;
         endcase
      end
   end
endmodule

// File: rtl/nnx_clamp.sv
module nnx_clamp #(
   parameter int XLEN  = 32,
   parameter int POS_W = 7
) (
   input  logic [XLEN-1:0]  val_i,
   input  logic [XLEN-1:0]  shamt_i,
   input  logic [POS_W-1:0] pos_i,
   output logic [XLEN-1:0]  res_o,
   output logic             ok_o
);
   localparam int SH_W = $clog2(XLEN);
   localparam int EXT  = XLEN + 2;
   localparam logic [POS_W-1:0] POS_MAX = POS_W'(XLEN);
   localparam logic [XLEN-1:0]  SH_LIM  = XLEN'(XLEN);

   logic signed [XLEN-1:0] shifted;
   logic signed [EXT-1:0]  sx;
   logic [EXT-1:0]         one_u;
   logic signed [EXT-1:0]  hi;
   logic signed [EXT-1:0]  lo;
   logic [POS_W-1:0]       pos_m1;

   assign ok_o    = (pos_i != '0) && (pos_i <= POS_MAX) && (shamt_i < SH_LIM);
   assign shifted = $signed(val_i) >>> shamt_i[SH_W-1:0];
   assign sx      = $signed({{2{shifted[XLEN-1]}}, shifted});

   // Limits are built two bits wider than the datapath so p = XLEN cannot overflow.
   assign pos_m1  = pos_i - 1'b1;
   assign one_u   = {{(EXT-1){1'b0}}, 1'b1} << pos_m1;
   assign hi      = $signed(one_u) - 1;
   assign lo      = -$signed(one_u);

   always_comb begin
      if (sx > hi)      res_o = hi[XLEN-1:0];
      else if (sx < lo) res_o = lo[XLEN-1:0];
      else              res_o = shifted;
   end
endmodule

// File: rtl/nnx_dot.sv
module nnx_dot #(
   parameter int XLEN   = 32,
   parameter int LANE_W = 8
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  logic [XLEN-1:0] acc_i,
   output logic [XLEN-1:0] res_o
);
   localparam int N_LANES = XLEN / LANE_W;
   localparam int PROD_W  = 2 * LANE_W;
   localparam int SUM_W   = PROD_W + $clog2(N_LANES) + 1;

   logic signed [PROD_W-1:0] prod [N_LANES];
   logic signed [SUM_W-1:0]  psum;

   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      assign prod[g] = $signed(a_i[g*LANE_W +: LANE_W]) * $signed(b_i[g*LANE_W +: LANE_W]);
   end

   always_comb begin
      psum = '0;
      for (int i = 0; i < N_LANES; i++) begin
         psum = psum + $signed({{(SUM_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]});
      end
   end

   if (SUM_W < XLEN) begin : g_ext
      assign res_o = acc_i + {{(XLEN-SUM_W){psum[SUM_W-1]}}, psum};
   end else begin : g_trunc
      assign res_o = acc_i + psum[XLEN-1:0];
   end
endmodule

// File: rtl/nnx_macc.sv
module nnx_macc #(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] a_i,
   input  logic [XLEN-1:0] b_i,
   input  logic [XLEN-1:0] acc_i,
   output logic [XLEN-1:0] res_o
);
   logic signed [2*XLEN-1:0] full;

   assign full  = $signed(a_i) * $signed(b_i);
   assign res_o = full[XLEN-1:0] + acc_i;
endmodule

// File: rtl/nnx_unit.sv
module nnx_unit
   import nnx_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int LANE_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            issue_i,
   input  logic [31:0]     instr_i,
   input  logic [XLEN-1:0] src1_i,
   input  logic [XLEN-1:0] src2_i,
   input  logic [XLEN-1:0] src3_i,
   output logic            wb_en_o,
   output logic [4:0]      wb_idx_o,
   output logic [XLEN-1:0] wb_data_o,
   output logic            illegal_o
);
   localparam int POS_W = 7;

   if ((XLEN % LANE_W) != 0 || (XLEN / LANE_W) < 2) begin : g_bad_lanes
      $error("nnx_unit: XLEN must hold at least two whole lanes");
   end
   if ((1 << POS_W) <= XLEN) begin : g_bad_pos
      $error("nnx_unit: position field cannot reach XLEN");
   end

   nnx_dec_t        dec;
   logic [XLEN-1:0] clamp_res, dot_res, macc_res;
   logic            clamp_ok;
   logic            do_wr;
   logic [XLEN-1:0] res_mux;

   nnx_decode u_dec (.instr_i(instr_i), .dec_o(dec));

   nnx_clamp #(.XLEN(XLEN), .POS_W(POS_W)) u_clamp (
      .val_i(src1_i), .shamt_i(src2_i), .pos_i(dec.pos),
      .res_o(clamp_res), .ok_o(clamp_ok)
   );

   nnx_dot #(.XLEN(XLEN), .LANE_W(LANE_W)) u_dot (
      .a_i(src1_i), .b_i(src2_i), .acc_i(src3_i), .res_o(dot_res)
   );

   nnx_macc #(.XLEN(XLEN)) u_macc (
      .a_i(src1_i), .b_i(src2_i), .acc_i(src3_i), .res_o(macc_res)
   );

   always_comb begin
      unique case (dec.op)
         OP_CLAMP: begin do_wr = clamp_ok; res_mux = clamp_res; end
         OP_DOT:   begin do_wr = 1'b1;     res_mux = dot_res;   end
         OP_MACC:  begin do_wr = 1'b1;     res_mux = macc_res;  end
         default:  begin do_wr = 1'b0;     res_mux = '0;        end
      endcase
      if (dec.rd == 5'd0) do_wr = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wb_en_o   <= 1'b0;
         illegal_o <= 1'b0;
         wb_idx_o  <= '0;
         wb_data_o <= '0;
      end else begin
         wb_en_o   <= issue_i & do_wr;
         illegal_o <= issue_i & dec.bad;
         wb_idx_o  <= dec.rd;
         wb_data_o <= res_mux;
      end
   end
endmodule

// File: rtl/nnx_unit_chk.sv
module nnx_unit_chk #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            issue_i,
   input logic [31:0]     instr_i,
   input logic [XLEN-1:0] src1_i,
   input logic [XLEN-1:0] src2_i,
   input logic [XLEN-1:0] src3_i,
   input logic            wb_en_o,
   input logic [4:0]      wb_idx_o,
   input logic [XLEN-1:0] wb_data_o,
   input logic            illegal_o
);
   logic own_op;
   assign own_op = (instr_i[6:0] == 7'b0101011);

   AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!wb_en_o && !illegal_o)); // R1
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_i |=> (!wb_en_o && !illegal_o)); // R2
   AST_FOREIGN_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !own_op) |=> (!wb_en_o && !illegal_o)); // R3
   AST_SHIFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && own_op && instr_i[14:12] == 3'd0 && src2_i >= XLEN'(XLEN))
         |=> (!wb_en_o && !illegal_o)); // R5
   AST_MACC_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && own_op && instr_i[14:12] == 3'd2 && instr_i[31:25] == 7'd0
         && instr_i[11:7] != 5'd0)
         |=> (wb_en_o && wb_data_o == XLEN'($past(src1_i) * $past(src2_i) + $past(src3_i)))); // R8
   AST_ZERO_DEST: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && instr_i[11:7] == 5'd0) |=> !wb_en_o); // R9
   AST_NOT_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      !(wb_en_o && illegal_o)); // R10
   AST_DEST_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i |=> (!wb_en_o || wb_idx_o == $past(instr_i[11:7]))); // R11
endmodule

bind nnx_unit nnx_unit_chk #(.XLEN(XLEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
   .src1_i(src1_i), .src2_i(src2_i), .src3_i(src3_i),
   .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o),
   .illegal_o(illegal_o)
);

// File: tb/nnx_unit_tb.sv
module nnx_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_i = 1'b0;
   logic [31:0] instr_i = '0;
   logic [31:0] src1_i = '0, src2_i = '0, src3_i = '0;
   logic        wb_en_o, illegal_o;
   logic [4:0]  wb_idx_o;
   logic [31:0] wb_data_o;

   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   nnx_unit u_dut (
      .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
      .src1_i(src1_i), .src2_i(src2_i), .src3_i(src3_i),
      .wb_en_o(wb_en_o), .wb_idx_o(wb_idx_o), .wb_data_o(wb_data_o),
      .illegal_o(illegal_o)
   );

   function automatic logic [31:0] enc(input logic [6:0] f7, input logic [2:0] f3,
                                       input logic [4:0] rd, input logic [6:0] opc = 7'b0101011);
      return {f7, 5'd2, 5'd1, f3, rd, opc};
   endfunction

   function automatic logic [31:0] ref_clamp(input logic [31:0] a, input logic [31:0] sh, input int p);
      longint v, lim;
      v   = longint'($signed(a)) >>> sh;
      lim = longint'(1) << (p - 1);
      if (v > lim - 1)   v = lim - 1;
      else if (v < -lim) v = -lim;
      return v[31:0];
   endfunction

   function automatic logic [31:0] ref_dot(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
      int s = 0;
      for (int k = 0; k < 4; k++)
         s += int'($signed(a[8*k +: 8])) * int'($signed(b[8*k +: 8]));
      return 32'(s + int'(c));
   endfunction

   function automatic logic [31:0] ref_macc(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
      longint p;
      p = longint'($signed(a)) * longint'($signed(b)) + longint'($signed(c));
      return p[31:0];
   endfunction

   task automatic apply(input logic iss, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
      @(negedge clk);
      issue_i = iss; instr_i = ins; src1_i = a; src2_i = b; src3_i = c;
      @(negedge clk);
      issue_i = 1'b0;
   endtask

   task automatic check(input string req, input logic en, input logic ill,
                        input logic [4:0] idx, input logic [31:0] data);
      n_vec++;
      if (wb_en_o !== en || illegal_o !== ill || (en && (wb_idx_o !== idx || wb_data_o !== data))) begin
         n_bad++;
         $display("FAIL %s: got en=%b ill=%b idx=%0d data=%h, expected en=%b ill=%b idx=%0d data=%h",
                  req, wb_en_o, illegal_o, wb_idx_o, wb_data_o, en, ill, idx, data);
      end
   endtask

   task automatic t_reset;
      #1;
      check("R1 during reset", 1'b0, 1'b0, 5'd0, 32'd0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", 1'b0, 1'b0, 5'd0, 32'd0);
   endtask

   task automatic t_clamp_basic;
      apply(1'b1, enc(7'd8, 3'd0, 5'd3), 32'h8000_0000, 32'd4, 32'd0);
      check("R4 low clamp p=8", 1'b1, 1'b0, 5'd3, 32'hFFFF_FF80);
      apply(1'b1, enc(7'd8, 3'd0, 5'd4), 32'd1000, 32'd2, 32'd0);
      check("R4 high clamp p=8", 1'b1, 1'b0, 5'd4, 32'd127);
      apply(1'b1, enc(7'd4, 3'd0, 5'd5), 32'hFFFF_FFFB, 32'd0, 32'd0);
      check("R4 in range p=4", 1'b1, 1'b0, 5'd5, ref_clamp(32'hFFFF_FFFB, 32'd0, 4));
      apply(1'b1, enc(7'd1, 3'd0, 5'd6), 32'd5, 32'd0, 32'd0);
      check("R4 p=1", 1'b1, 1'b0, 5'd6, 32'd0);
      apply(1'b1, enc(7'd16, 3'd0, 5'd7), 32'hFF12_3456, 32'd3, 32'd0);
      check("R4 p=16", 1'b1, 1'b0, 5'd7, ref_clamp(32'hFF12_3456, 32'd3, 16));
   endtask

   task automatic t_clamp_full;
      apply(1'b1, enc(7'd32, 3'd0, 5'd8), 32'h8000_0000, 32'd0, 32'd0);
      check("R6 p=32 minimum", 1'b1, 1'b0, 5'd8, 32'h8000_0000);
      apply(1'b1, enc(7'd32, 3'd0, 5'd9), 32'h7FFF_FFFF, 32'd0, 32'd0);
      check("R6 p=32 maximum", 1'b1, 1'b0, 5'd9, 32'h7FFF_FFFF);
      apply(1'b1, enc(7'd32, 3'd0, 5'd10), 32'h8000_0000, 32'd31, 32'd0);
      check("R6 p=32 shift 31", 1'b1, 1'b0, 5'd10, 32'hFFFF_FFFF);
   endtask

   task automatic t_clamp_reject;
      apply(1'b1, enc(7'd0, 3'd0, 5'd3), 32'd9, 32'd0, 32'd0);
      check("R5 p=0", 1'b0, 1'b0, 5'd0, 32'd0);
      apply(1'b1, enc(7'd33, 3'd0, 5'd3), 32'd9, 32'd0, 32'd0);
      check("R5 p=33", 1'b0, 1'b0, 5'd0, 32'd0);
      apply(1'b1, enc(7'd8, 3'd0, 5'd3), 32'd9, 32'd32, 32'd0);
      check("R5 shift 32", 1'b0, 1'b0, 5'd0, 32'd0);
      apply(1'b1, enc(7'd8, 3'd0, 5'd3), 32'd9, 32'h8000_0001, 32'd0);
      check("R5 shift huge", 1'b0, 1'b0, 5'd0, 32'd0);
   endtask

   task automatic t_dot;
      apply(1'b1, enc(7'd0, 3'd1, 5'd11), 32'h8080_8080, 32'h8080_8080, 32'd5);
      check("R7 extreme lanes", 1'b1, 1'b0, 5'd11, 32'd65541);
      apply(1'b1, enc(7'd0, 3'd1, 5'd12), 32'h01FF_7F80, 32'h0302_7F01, 32'd100);
      check("R7 mixed lanes", 1'b1, 1'b0, 5'd12, ref_dot(32'h01FF_7F80, 32'h0302_7F01, 32'd100));
      apply(1'b1, enc(7'd0, 3'd1, 5'd13), 32'h0000_0002, 32'h0000_0003, 32'h7FFF_FFFF);
      check("R7 accumulator wrap", 1'b1, 1'b0, 5'd13, 32'h8000_0005);
   endtask

   task automatic t_macc;
      apply(1'b1, enc(7'd0, 3'd2, 5'd14), 32'hFFFF_FFFD, 32'd7, 32'd100);
      check("R8 negative product", 1'b1, 1'b0, 5'd14, 32'd79);
      apply(1'b1, enc(7'd0, 3'd2, 5'd15), 32'h1234_5678, 32'h8765_4321, 32'hDEAD_BEEF);
      check("R8 large operands", 1'b1, 1'b0, 5'd15, ref_macc(32'h1234_5678, 32'h8765_4321, 32'hDEAD_BEEF));
      apply(1'b1, enc(7'd0, 3'd2, 5'd16), 32'h8000_0000, 32'h8000_0000, 32'd1);
      check("R8 min times min", 1'b1, 1'b0, 5'd16, 32'd1);
   endtask

   task automatic t_zero_dest;
      apply(1'b1, enc(7'd8, 3'd0, 5'd0), 32'd9, 32'd0, 32'd0);
      check("R9 saturate rd=0", 1'b0, 1'b0, 5'd0, 32'd0);
      apply(1'b1, enc(7'd0, 3'd1, 5'd0), 32'h0101_0101, 32'h0101_0101, 32'd0);
      check("R9 dot rd=0", 1'b0, 1'b0, 5'd0, 32'd0);
      apply(1'b1, enc(7'd0, 3'd2, 5'd0), 32'd3, 32'd3, 32'd0);
      check("R9 macc rd=0", 1'b0, 1'b0, 5'd0, 32'd0);
   endtask

   task automatic t_illegal;
      apply(1'b1, enc(7'd1, 3'd1, 5'd5), 32'd1, 32'd1, 32'd0);
      check("R10 dot funct7", 1'b0, 1'b1, 5'd0, 32'd0);
      apply(1'b1, enc(7'd64, 3'd2, 5'd5), 32'd1, 32'd1, 32'd0);
      check("R10 macc funct7", 1'b0, 1'b1, 5'd0, 32'd0);
      for (int f = 3; f < 8; f++) begin
         apply(1'b1, enc(7'd0, 3'(f), 5'd5), 32'd1, 32'd1, 32'd0);
         check("R10 unused funct3", 1'b0, 1'b1, 5'd0, 32'd0);
      end
   endtask

   task automatic t_foreign;
      apply(1'b1, enc(7'd0, 3'd2, 5'd5, 7'b0001011), 32'd2, 32'd2, 32'd0);
      check("R3 other opcode", 1'b0, 1'b0, 5'd0, 32'd0);
      apply(1'b1, enc(7'd9, 3'd5, 5'd5, 7'b0110011), 32'd2, 32'd2, 32'd0);
      check("R3 other opcode bad fields", 1'b0, 1'b0, 5'd0, 32'd0);
   endtask

   task automatic t_idle;
      apply(1'b0, enc(7'd0, 3'd2, 5'd5), 32'd2, 32'd2, 32'd0);
      check("R2 no issue", 1'b0, 1'b0, 5'd0, 32'd0);
      apply(1'b0, enc(7'd0, 3'd6, 5'd5), 32'd2, 32'd2, 32'd0);
      check("R2 no issue illegal encoding", 1'b0, 1'b0, 5'd0, 32'd0);
      apply(1'b1, enc(7'd0, 3'd2, 5'd17), 32'd6, 32'd7, 32'd0);
      check("R2 R11 issued result", 1'b1, 1'b0, 5'd17, 32'd42);
      @(negedge clk);
      check("R2 drop after issue", 1'b0, 1'b0, 5'd0, 32'd0);
   endtask

   initial begin
      t_reset();
      t_clamp_basic();
      t_clamp_full();
      t_clamp_reject();
      t_dot();
      t_macc();
      t_zero_dest();
      t_illegal();
      t_foreign();
      t_idle();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 5);
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule